// File: doc/BRIEF.md
# Quadrature Position Counter with Byte Command Port

This block is a single 24-bit position counter driven by an incremental encoder's two phase signals. Both phases pass through a synchronizer and are decoded at four counts per line, so each legal edge of either phase moves the count by one in the direction of rotation. A host controls the counter only through single-byte commands on a command stream, a byte-wide write stream and a byte-wide read stream.

To read the position, the host rewinds the shared byte pointer, snapshots the live count into a 24-bit capture register, and then takes three bytes from the read stream: low, middle, high. The same pointer steers write bytes into a 24-bit preset register. The preset can be moved into the counter, and its low byte can be moved into an 8-bit divider register that is visible on an output pin. A sticky wrap flag records that the counter has crossed between all-ones and zero.

All three streams use valid/ready. The block never applies back-pressure: `cmd_ready` and `wr_ready` are tied high, and a byte is taken on every cycle in which its valid is high. The read stream always presents `rd_valid` high together with the byte the pointer selects. A byte is consumed, and the pointer advances, only in a cycle with `rd_ready` high, so the host may stall reads for as long as it likes.

Top module: `qcnt_channel`

## Requirements
- R1: After reset the counter, capture register, preset, divider, wrap flag and byte pointer are all zero, and both counting enables are off, so `rd_data` reads 0x00.
- R2: Each phase pair is mapped to a position p = {A, A^B}. A change of p by +1 (mod 4) adds one to the counter, a change of -1 subtracts one, and a change of 2 (both phases flipping at once) or 0 leaves the counter unchanged. Outside command cycles the counter moves by at most one per clock.
- R3: The counter ignores phase activity until both command 0x41 (input enable) and command 0x38 (x4 quadrature mode) have been received since reset.
- R4: The counter wraps modulo 2^24: one step down from zero gives 0xFFFFFF, and one step up from 0xFFFFFF gives zero. Every wrap sets `wrap_flag`. Command 0x06 clears the flag, and the clear wins over a wrap in the same cycle.
- R5: Command 0x02 sets the counter to zero. It takes priority over a preset load and over a phase step in the same cycle.
- R6: Command 0x10 copies the live counter into the capture register, which then holds that value while the counter moves on.
- R7: Command 0x01 sets the byte pointer to 0. Each accepted read returns capture bits [7:0], then [15:8], then [23:16]. The pointer stops at the high byte, so further reads repeat the high byte.
- R8: An accepted write stores its byte into the preset byte that the pointer selects (0 is bits [7:0]) and advances the pointer, which stops at the high byte. Command 0x08 copies the preset into the counter.
- R9: Command 0x18 copies preset bits [7:0] onto `clk_div`. The value 0x00 is a valid divider value.
- R10: `cmd_ready`, `wr_ready` and `rd_valid` are always high. A command byte other than 0x01, 0x02, 0x06, 0x08, 0x10, 0x18, 0x38 or 0x41 changes no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| phase_a | input | 1 | Encoder phase A, asynchronous |
| phase_b | input | 1 | Encoder phase B, asynchronous |
| cmd_valid | input | 1 | Command byte valid |
| cmd_ready | output | 1 | Command accepted (always high) |
| cmd_byte | input | 8 | Command code |
| wr_valid | input | 1 | Write byte valid |
| wr_ready | output | 1 | Write accepted (always high) |
| wr_data | input | 8 | Byte for the preset register |
| rd_valid | output | 1 | Read byte available (always high) |
| rd_ready | input | 1 | Host takes the read byte, pointer advances |
| rd_data | output | 8 | Capture-register byte the pointer selects |
| wrap_flag | output | 1 | Sticky counter-wrap flag |
| clk_div | output | 8 | Divider value loaded by command 0x18 |

## Verification
The assertions assume that the host raises `cmd_valid` only when it means to issue a command, because a cycle with a command is exempt from the step-size bound. They also assume that the phase inputs change slowly enough that the decoder sees each edge separately. The bench drives at most one phase change at a time, except when it deliberately flips both phases together. It then holds the phases steady for four clocks, which covers the two synchronizer stages and the decoder register, before it issues any command. No commands are issued while a phase edge is still passing through the synchronizer.

// File: rtl/qcnt_pkg.sv
package qcnt_pkg;
  localparam logic [7:0] OP_PTR_CLR  = 8'h01;
  localparam logic [7:0] OP_CNT_CLR  = 8'h02;
  localparam logic [7:0] OP_FLAG_CLR = 8'h06;
  localparam logic [7:0] OP_LOAD     = 8'h08;
  localparam logic [7:0] OP_CAPTURE  = 8'h10;
  localparam logic [7:0] OP_DIV_LOAD = 8'h18;
  localparam logic [7:0] OP_QUAD4    = 8'h38;
  localparam logic [7:0] OP_IN_EN    = 8'h41;

  typedef struct packed {
    logic ptr_clr;
    logic cnt_clr;
    logic flag_clr;
    logic load;
    logic capture;
    logic div_load;
    logic quad4;
    logic in_en;
  } op_t;

  function automatic op_t decode_op(input logic vld, input logic [7:0] code);
    op_t d;
    d = '0;
    if (vld) begin
      case (code)
        OP_PTR_CLR:  d.ptr_clr  = 1'b1;
        OP_CNT_CLR:  d.cnt_clr  = 1'b1;
        OP_FLAG_CLR: d.flag_clr = 1'b1;
        OP_LOAD:     d.load     = 1'b1;
        OP_CAPTURE:  d.capture  = 1'b1;
        OP_DIV_LOAD: d.div_load = 1'b1;
        OP_QUAD4:    d.quad4    = 1'b1;
        OP_IN_EN:    d.in_en    = 1'b1;
        default:     d = '0;
      endcase
    end
    return d;
  endfunction
endpackage

// File: rtl/qcnt_sync.sv
module qcnt_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/qcnt_quad.sv
module qcnt_quad (
  input  logic clk,
  input  logic rst_n,
  input  logic a,
  input  logic b,
  output logic up,
  output logic dn
);
  logic [1:0] pos_now, pos_prev, diff;

  assign pos_now = {a, a ^ b};
  assign diff    = pos_now - pos_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) pos_prev <= 2'b00;
    else        pos_prev <= pos_now;
  end

  // +1 forward, +3 (== -1) backward, +2 is an illegal double edge
  assign up = (diff == 2'd1);
  assign dn = (diff == 2'd3);
endmodule

// File: rtl/qcnt_bytes.sv
module qcnt_bytes #(
  parameter int CNT_W = 24,
  localparam int NB   = CNT_W / 8,
  localparam int PW   = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ptr_clr,
  input  logic             wr_fire,
  input  logic [7:0]       wr_byte,
  input  logic             rd_fire,
  input  logic [CNT_W-1:0] snap,
  output logic [CNT_W-1:0] preset,
  output logic [7:0]       rd_byte,
  output logic [PW-1:0]    ptr
);
  localparam logic [PW-1:0] PTR_LAST = PW'(NB - 1);

  always_ff @(posedge clk) begin
    if (!rst_n)                              ptr <= '0;
    else if (ptr_clr)                        ptr <= '0;
    else if ((wr_fire || rd_fire) && ptr != PTR_LAST) ptr <= ptr + 1'b1;
  end

  for (genvar g = 0; g < NB; g++) begin : g_byte
    always_ff @(posedge clk) begin
      if (!rst_n)                              preset[g*8 +: 8] <= '0;
      else if (wr_fire && ptr == PW'(g))       preset[g*8 +: 8] <= wr_byte;
    end
  end

  assign rd_byte = snap[8*int'(ptr) +: 8];
endmodule

// File: rtl/qcnt_channel.sv
module qcnt_channel #(
  parameter int CNT_W       = 24,
  parameter int SYNC_STAGES = 2,
  localparam int NB         = CNT_W / 8,
  localparam int PW         = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       phase_a,
  input  logic       phase_b,
  input  logic       cmd_valid,
  output logic       cmd_ready,
  input  logic [7:0] cmd_byte,
  input  logic       wr_valid,
  output logic       wr_ready,
  input  logic [7:0] wr_data,
  output logic       rd_valid,
  input  logic       rd_ready,
  output logic [7:0] rd_data,
  output logic       wrap_flag,
  output logic [7:0] clk_div
);
  import qcnt_pkg::*;

  logic [1:0]       ph_sync;
  logic             step_up, step_dn;
  logic [CNT_W-1:0] count_q, latch_q, preset_q;
  logic [PW-1:0]    byte_ptr;
  logic             en_in_q, en_quad_q, cnt_on, wrap_evt;
  op_t              op;

  assign cmd_ready = 1'b1;
  assign wr_ready  = 1'b1;
  assign rd_valid  = 1'b1;

  assign op = decode_op(cmd_valid && cmd_ready, cmd_byte);

  qcnt_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({phase_a, phase_b}), .q(ph_sync)
  );

  qcnt_quad u_quad (
    .clk(clk), .rst_n(rst_n), .a(ph_sync[1]), .b(ph_sync[0]),
    .up(step_up), .dn(step_dn)
  );

  qcnt_bytes #(.CNT_W(CNT_W)) u_bytes (
    .clk(clk), .rst_n(rst_n), .ptr_clr(op.ptr_clr),
    .wr_fire(wr_valid && wr_ready), .wr_byte(wr_data),
    .rd_fire(rd_valid && rd_ready), .snap(latch_q),
    .preset(preset_q), .rd_byte(rd_data), .ptr(byte_ptr)
  );

  assign cnt_on   = en_in_q && en_quad_q;
  assign wrap_evt = cnt_on && !op.cnt_clr && !op.load &&
                    ((step_up && count_q == '1) || (step_dn && count_q == '0));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_in_q   <= 1'b0;
      en_quad_q <= 1'b0;
    end else begin
      if (op.in_en) en_in_q   <= 1'b1;
      if (op.quad4) en_quad_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                     count_q <= '0;
    else if (op.cnt_clr)            count_q <= '0;
    else if (op.load)               count_q <= preset_q;
    else if (cnt_on && step_up)     count_q <= count_q + 1'b1;
    else if (cnt_on && step_dn)     count_q <= count_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          latch_q <= '0;
    else if (op.capture) latch_q <= count_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          wrap_flag <= 1'b0;
    else if (op.flag_clr) wrap_flag <= 1'b0;
    else if (wrap_evt)   wrap_flag <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)           clk_div <= '0;
    else if (op.div_load) clk_div <= preset_q[7:0];
  end
endmodule

// File: rtl/qcnt_channel_chk.sv
module qcnt_channel_chk #(
  parameter int CNT_W = 24,
  parameter int PW    = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic [7:0]       cmd_byte,
  input logic [CNT_W-1:0] count_q,
  input logic [CNT_W-1:0] latch_q,
  input logic [CNT_W-1:0] preset_q,
  input logic [PW-1:0]    byte_ptr,
  input logic             cnt_on,
  input logic             wrap_flag
);
  localparam int NB = CNT_W / 8;

  assert_step_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> (count_q == $past(count_q)) ||
                   (count_q == $past(count_q) + 1'b1) ||
                   (count_q == $past(count_q) - 1'b1));

  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_on && !cmd_valid) |=> $stable(count_q));

  assert_flag_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_byte == 8'h06) |=> !wrap_flag);

  assert_count_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_byte == 8'h02) |=> count_q == '0);

  assert_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_byte == 8'h10) |=> latch_q == $past(count_q));

  assert_ptr_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    int'(byte_ptr) <= NB - 1);

  assert_preset_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_byte == 8'h08) |=> count_q == $past(preset_q));
endmodule

bind qcnt_channel qcnt_channel_chk #(.CNT_W(CNT_W), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
  .count_q(count_q), .latch_q(latch_q), .preset_q(preset_q),
  .byte_ptr(byte_ptr), .cnt_on(cnt_on), .wrap_flag(wrap_flag)
);

// File: tb/test_qcnt_channel.sv
module test_qcnt_channel;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic phase_a = 1'b0, phase_b = 1'b0;
  logic cmd_valid = 1'b0, wr_valid = 1'b0, rd_ready = 1'b0;
  logic [7:0] cmd_byte = '0, wr_data = '0;
  logic cmd_ready, wr_ready, rd_valid, wrap_flag;
  logic [7:0] rd_data, clk_div;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  int pos = 0;
  logic [23:0] exp_cnt = '0;
  bit counting = 0;

  always #2.5 clk = ~clk;

  qcnt_channel i_qcnt_channel (
    .clk(clk), .rst_n(rst_n), .phase_a(phase_a), .phase_b(phase_b),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_byte(cmd_byte),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .wrap_flag(wrap_flag), .clk_div(clk_div)
  );

  task automatic chk(input string req, input logic [23:0] got, input logic [23:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic cmd(input logic [7:0] b);
    cmd_valid = 1'b1; cmd_byte = b; tick(); cmd_valid = 1'b0;
  endtask

  task automatic wr(input logic [7:0] b);
    wr_valid = 1'b1; wr_data = b; tick(); wr_valid = 1'b0;
  endtask

  task automatic pop(output logic [7:0] b);
    b = rd_data; rd_ready = 1'b1; tick(); rd_ready = 1'b0;
  endtask

  task automatic read_count(output logic [23:0] v);
    logic [7:0] lo, mid, hi;
    cmd(8'h01); cmd(8'h10);
    pop(lo); pop(mid); pop(hi);
    v = {hi, mid, lo};
  endtask

  // position p maps to phases A = p[1], B = p[1]^p[0]
  task automatic jump(input int to);
    int d;
    d = (to - pos) & 3;
    if (counting && d == 1) exp_cnt = exp_cnt + 24'd1;
    if (counting && d == 3) exp_cnt = exp_cnt - 24'd1;
    pos = to & 3;
    phase_a = pos[1];
    phase_b = pos[1] ^ pos[0];
    repeat (4) tick();
  endtask

  task automatic move(input int dir, input int n);
    for (int i = 0; i < n; i++) jump(pos + dir);
  endtask

  initial begin
    logic [23:0] v;
    logic [7:0] b;
    repeat (4) tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    chk("R1 rd_data", {16'h0, rd_data}, 24'h0);
    chk("R1 wrap_flag", {23'h0, wrap_flag}, 24'h0);
    chk("R1 clk_div", {16'h0, clk_div}, 24'h0);
    // R10 handshakes
    chk("R10 ready/valid", {21'h0, cmd_ready, wr_ready, rd_valid}, 24'h7);
    // R3 no counting before enable
    move(1, 5);
    read_count(v); chk("R3 no enable", v, 24'h0);
    cmd(8'h41);
    move(1, 3);
    read_count(v); chk("R3 input enable only", v, 24'h0);
    // init sequence
    cmd(8'h06); cmd(8'h01); wr(8'h00); cmd(8'h18);
    cmd(8'h41); cmd(8'h38); cmd(8'h02);
    counting = 1; exp_cnt = '0;
    chk("R9 divider zero", {16'h0, clk_div}, 24'h0);
    read_count(v); chk("R5 after init", v, 24'h0);
    // R2 up and down
    move(1, 3);
    read_count(v); chk("R2 up three", v, exp_cnt);
    move(-1, 5);
    read_count(v); chk("R4 underflow value", v, 24'hFFFFFE);
    chk("R4 flag set on underflow", {23'h0, wrap_flag}, 24'h1);
    cmd(8'h06);
    chk("R4 flag cleared", {23'h0, wrap_flag}, 24'h0);
    // R2 sweep of every (from, to) pair
    for (int p = 0; p < 4; p++) begin
      for (int c = 0; c < 4; c++) begin
        jump(p);
        read_count(v); chk("R2 sweep from", v, exp_cnt);
        jump(c);
        read_count(v); chk("R2 sweep to", v, exp_cnt);
      end
    end
    // R5 clear
    cmd(8'h02); exp_cnt = '0;
    read_count(v); chk("R5 clear", v, 24'h0);
    // R8 preset load
    cmd(8'h01); wr(8'h56); wr(8'h34); wr(8'h12); cmd(8'h08);
    exp_cnt = 24'h123456;
    read_count(v); chk("R8 preset load", v, 24'h123456);
    cmd(8'h01); wr(8'hAA); wr(8'hBB); wr(8'hCC); wr(8'hDD); cmd(8'h08);
    exp_cnt = 24'hDDBBAA;
    read_count(v); chk("R8 write pointer stops", v, 24'hDDBBAA);
    // R7 pointer stops at high byte on reads
    pop(b); chk("R7 fourth read", {16'h0, b}, 24'h0000DD);
    pop(b); chk("R7 fifth read", {16'h0, b}, 24'h0000DD);
    // R6 capture holds while counter moves
    move(1, 2);
    cmd(8'h01);
    begin
      logic [7:0] l0, l1, l2;
      pop(l0); pop(l1); pop(l2);
      chk("R6 capture held", {l2, l1, l0}, 24'hDDBBAA);
    end
    read_count(v); chk("R6 new capture", v, 24'hDDBBAC);
    // R4 wrap up from all ones
    cmd(8'h01); wr(8'hFF); wr(8'hFF); wr(8'hFF); cmd(8'h08);
    exp_cnt = 24'hFFFFFF;
    move(1, 1);
    read_count(v); chk("R4 overflow value", v, 24'h0);
    chk("R4 flag set on overflow", {23'h0, wrap_flag}, 24'h1);
    // R9 divider load
    cmd(8'h01); wr(8'h5A); cmd(8'h18);
    chk("R9 divider", {16'h0, clk_div}, 24'h00005A);
    // R10 unknown command changes nothing
    cmd(8'h55);
    chk("R10 unknown keeps flag", {23'h0, wrap_flag}, 24'h1);
    chk("R10 unknown keeps divider", {16'h0, clk_div}, 24'h00005A);
    read_count(v); chk("R10 unknown keeps count", v, 24'h0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule